// File: doc/BRIEF.md
# Streaming Page Parity Encoder

This block protects a page of `K_ROWS` data bytes, each `M_BITS` wide, that streams through it one byte per clock. It passes every accepted byte to its output one cycle later, and in parallel builds two kinds of check information. The column check byte is the bitwise XOR of all data bytes. The row check bits come in pairs: each byte's overall parity is steered into one member of every pair according to the bits of its row number.

Once the final data byte has gone out, the encoder appends the column check byte followed by the packed row check bytes. The whole codeword of `K_ROWS + R` bytes therefore leaves in `K_ROWS + R` output cycles when input arrives without gaps. A start pulse opens each page and wipes any partial state. The row scheme needs only `2*log2(K_ROWS)` bits instead of one bit per row. `K_ROWS` must be a power of two and at least 2.

Top module: `xp_page_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` and `out_last_o` stay low until a page is started.
- R2: Each accepted byte appears unchanged on `out_data_o` exactly one cycle later, with `out_valid_o` high and `out_last_o` low.
- R3: A byte is accepted only when `in_valid_i` is high and either `start_i` is high or the page is still collecting data bytes. Bytes offered while idle or while check bytes are being emitted produce no output and do not alter the check bytes.
- R4: The first check byte equals the bitwise XOR of the `K_ROWS` data bytes of the page.
- R5: For pair x (x from 1 to log2(K_ROWS)), bit 2(x-1) of the packed row vector is the XOR of the parities of all data bytes whose row number has bit x-1 set, and bit 2(x-1)+1 is the same over rows where that bit is clear. The vector is sent least significant byte first in `ceil(2*log2(K_ROWS)/M_BITS)` bytes, and unused high bits are zero.
- R6: The check bytes follow the last data byte on consecutive cycles with `out_valid_o` held high, and `out_last_o` is high on the final check byte only. A page produces exactly `K_ROWS + 1 + ceil(2*log2(K_ROWS)/M_BITS)` valid output bytes.
- R7: `start_i` clears all accumulated check state and the row counter, and abandons any page or check sequence in progress. A byte presented in the start cycle is row 0 of the new page. A start without a byte produces no output in the following cycle.
- R8: After the final check byte the output stays invalid until a new page delivers a byte.
- R9: Cycles with `in_valid_i` low during the data phase produce no output and do not advance the row number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new page and clears state |
| in_valid_i | input | 1 | Input byte qualifier |
| in_data_i | input | M_BITS | Input data byte |
| out_valid_o | output | 1 | Output byte qualifier |
| out_data_o | output | M_BITS | Data byte or check byte |
| out_last_o | output | 1 | Marks the final byte of the codeword |

## Verification
The bench aims at the row-number steering: a single set bit in one row must land in exactly the pair members picked by that row's index. An encoder that reversed the members or shifted the index by one bit would put the pattern in the wrong place. Pages restarted after seven bytes show whether the start pulse clears the accumulators, since stale state would corrupt the check bytes of the next page. Random input gaps test whether idle cycles wrongly advance the row counter, which would scramble the row bits. Bytes driven during the check-byte phase test whether the encoder wrongly accepts them, which would emit extra bytes or alter the parity.

// File: rtl/xp_ecc_pkg.sv
package xp_ecc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DATA   = 2'd1,
    PH_PARITY = 2'd2
  } phase_e;

  function automatic int row_byte_count(input int log2k, input int mbits);
    return (2 * log2k + mbits - 1) / mbits;
  endfunction

endpackage

// File: rtl/xp_seq.sv
module xp_seq
  import xp_ecc_pkg::*;
#(
  parameter int K_ROWS  = 16,
  parameter int R_BYTES = 2,
  localparam int LOG2K  = $clog2(K_ROWS),
  localparam int PCNT_W = (R_BYTES > 1) ? $clog2(R_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  output logic              accept_o,
  output logic [LOG2K-1:0]  row_idx_o,
  output phase_e            phase_o,
  output logic [PCNT_W-1:0] par_idx_o,
  output logic              par_last_o
);

  phase_e            phase_q, phase_d;
  logic [LOG2K-1:0]  row_q, row_d;
  logic [PCNT_W-1:0] par_q, par_d;
  logic              st_en;
  logic              row_end;

  always_comb begin
    accept_o   = valid_i && (start_i || (phase_q == PH_DATA));
    row_idx_o  = start_i ? '0 : row_q;
    row_end    = (row_idx_o == LOG2K'(K_ROWS - 1));
    par_last_o = (phase_q == PH_PARITY) && (par_q == PCNT_W'(R_BYTES - 1));
    phase_o    = phase_q;
    par_idx_o  = par_q;

    phase_d = phase_q;
    row_d   = row_q;
    par_d   = par_q;
    if (start_i) begin
      phase_d = PH_DATA;
      row_d   = '0;
      par_d   = '0;
    end
    if (accept_o) begin
      row_d = row_idx_o + 1'b1;
      if (row_end) begin
        phase_d = PH_PARITY;
        par_d   = '0;
      end
    end else if ((phase_q == PH_PARITY) && !start_i) begin
      par_d = par_q + 1'b1;
      if (par_last_o) phase_d = PH_IDLE;
    end
    st_en = start_i | accept_o | (phase_q == PH_PARITY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      par_q   <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      row_q   <= row_d;
      par_q   <= par_d;
    end
  end

endmodule

// File: rtl/xp_col_accum.sv
module xp_col_accum #(
  parameter int M_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [M_BITS-1:0] data_i,
  output logic [M_BITS-1:0] col_o
);

  logic [M_BITS-1:0] col_q, col_d;
  logic              col_en;

  always_comb begin
    col_d  = (clear_i ? '0 : col_q) ^ (en_i ? data_i : '0);
    col_en = clear_i | en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_d;
  end

  assign col_o = col_q;

endmodule

// File: rtl/xp_row_accum.sv
module xp_row_accum #(
  parameter int M_BITS = 8,
  parameter int LOG2K  = 4,
  localparam int PAIR_BITS = 2 * LOG2K
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 en_i,
  input  logic [M_BITS-1:0]    data_i,
  input  logic [LOG2K-1:0]     row_idx_i,
  output logic [PAIR_BITS-1:0] pairs_o
);

  logic [PAIR_BITS-1:0] pair_q, pair_d, contrib;
  logic                 byte_par;
  logic                 pair_en;

  assign byte_par = ^data_i;

  for (genvar x = 0; x < LOG2K; x++) begin : g_pair
    assign contrib[2*x]   = en_i & byte_par &  row_idx_i[x];
    assign contrib[2*x+1] = en_i & byte_par & ~row_idx_i[x];
  end

  always_comb begin
    pair_d  = (clear_i ? '0 : pair_q) ^ contrib;
    pair_en = clear_i | en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pair_q <= '0;
    else if (pair_en) pair_q <= pair_d;
  end

  assign pairs_o = pair_q;

endmodule

// File: rtl/xp_page_encoder.sv
module xp_page_encoder
  import xp_ecc_pkg::*;
#(
  parameter int K_ROWS = 16,
  parameter int M_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [M_BITS-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [M_BITS-1:0] out_data_o,
  output logic              out_last_o
);

  localparam int LOG2K     = $clog2(K_ROWS);
  localparam int ROW_BITS  = 2 * LOG2K;
  localparam int ROW_BYTES = row_byte_count(LOG2K, M_BITS);
  localparam int R_BYTES   = 1 + ROW_BYTES;
  localparam int PCNT_W    = (R_BYTES > 1) ? $clog2(R_BYTES) : 1;
  localparam int PAD_BITS  = ROW_BYTES * M_BITS;

  logic              accept;
  logic [LOG2K-1:0]  row_idx;
  phase_e            phase;
  logic [PCNT_W-1:0] par_idx;
  logic              par_last;
  logic [M_BITS-1:0] col_par;
  logic [ROW_BITS-1:0] row_pairs;
  logic [PAD_BITS-1:0] row_pad;
  logic [M_BITS-1:0] par_bytes [R_BYTES];
  logic [M_BITS-1:0] par_sel;

  xp_seq #(.K_ROWS(K_ROWS), .R_BYTES(R_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .valid_i    (in_valid_i),
    .accept_o   (accept),
    .row_idx_o  (row_idx),
    .phase_o    (phase),
    .par_idx_o  (par_idx),
    .par_last_o (par_last)
  );

  xp_col_accum #(.M_BITS(M_BITS)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .en_i    (accept),
    .data_i  (in_data_i),
    .col_o   (col_par)
  );

  xp_row_accum #(.M_BITS(M_BITS), .LOG2K(LOG2K)) u_row (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .en_i      (accept),
    .data_i    (in_data_i),
    .row_idx_i (row_idx),
    .pairs_o   (row_pairs)
  );

  always_comb begin
    row_pad = '0;
    row_pad[ROW_BITS-1:0] = row_pairs;
  end

  assign par_bytes[0] = col_par;
  for (genvar b = 1; b < R_BYTES; b++) begin : g_rbyte
    assign par_bytes[b] = row_pad[(b-1)*M_BITS +: M_BITS];
  end

  always_comb begin
    par_sel = '0;
    for (int b = 0; b < R_BYTES; b++) begin
      if (par_idx == PCNT_W'(b)) par_sel = par_bytes[b];
    end
  end

  logic              ov_q, ov_d, ol_q, ol_d, o_en;
  logic [M_BITS-1:0] od_q, od_d;

  always_comb begin
    ov_d = 1'b0;
    ol_d = 1'b0;
    od_d = od_q;
    if (accept) begin
      ov_d = 1'b1;
      od_d = in_data_i;
    end else if (start_i) begin
      ov_d = 1'b0;
    end else if (phase == PH_PARITY) begin
      ov_d = 1'b1;
      od_d = par_sel;
      ol_d = par_last;
    end
    o_en = accept | start_i | (phase == PH_PARITY) | ov_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else if (o_en) begin
      ov_q <= ov_d;
      ol_q <= ol_d;
      od_q <= od_d;
    end
  end

  assign out_valid_o = ov_q;
  assign out_last_o  = ol_q;
  assign out_data_o  = od_q;

endmodule

// File: rtl/xp_page_encoder_chk.sv
module xp_page_encoder_chk #(
  parameter int M_BITS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              in_valid_i,
  input logic [M_BITS-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [M_BITS-1:0] out_data_o,
  input logic              out_last_o
);

  p_last_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o);

  p_quiet_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last_o && !(start_i && in_valid_i)) |=> !out_valid_o);

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && in_valid_i) |=> (out_valid_o && !out_last_o && out_data_o == $past(in_data_i)));

  p_start_no_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !in_valid_i) |=> !out_valid_o);

endmodule

bind xp_page_encoder xp_page_encoder_chk #(.M_BITS(M_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/xp_page_encoder_tb.sv
module xp_page_encoder_tb;

  localparam int K  = 16;
  localparam int M  = 8;
  localparam int LG = 4;
  localparam int RB = 1;
  localparam int RR = 1 + RB;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, in_valid_i;
  logic [M-1:0] in_data_i;
  logic         out_valid_o, out_last_o;
  logic [M-1:0] out_data_o;

  always #4 clk = ~clk;

  xp_page_encoder #(.K_ROWS(K), .M_BITS(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [M-1:0] pg [K];
  logic [M-1:0] cap_d [64];
  bit           cap_l [64];
  int           cap_c [64];
  int           cap_n = 0;
  bit           cap_en = 0;
  int           cyc = 0;

  initial forever begin
    @(posedge clk);
    #2;
    cyc++;
    if (cap_en && out_valid_o && cap_n < 64) begin
      cap_d[cap_n] = out_data_o;
      cap_l[cap_n] = out_last_o;
      cap_c[cap_n] = cyc;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [M-1:0] exp_col();
    logic [M-1:0] c = '0;
    for (int j = 0; j < K; j++) c ^= pg[j];
    return c;
  endfunction

  function automatic logic [M-1:0] exp_row(input int b);
    logic [RB*M-1:0] v = '0;
    for (int j = 0; j < K; j++) begin
      logic p;
      p = ^pg[j];
      for (int x = 0; x < LG; x++) begin
        if (((j >> x) & 1) == 1) v[2*x] ^= p;
        else                     v[2*x+1] ^= p;
      end
    end
    return v[b*M +: M];
  endfunction

  task automatic run_page(input int prefix, input bit swd, input int gap_pct,
                          input bit noise);
    logic [M-1:0] pre [K];
    int first;
    int exp_n;
    bit ok;
    string dtag;
    cap_n  = 0;
    cap_en = 1;
    for (int i = 0; i < prefix; i++) begin
      @(negedge clk);
      start_i = (i == 0); in_valid_i = 1'b1; in_data_i = M'($urandom);
      pre[i] = in_data_i;
    end
    @(negedge clk);
    start_i = 1'b1;
    if (swd) begin
      in_valid_i = 1'b1; in_data_i = pg[0]; first = 1;
    end else begin
      in_valid_i = 1'b0; in_data_i = M'($urandom); first = 0;
    end
    for (int j = first; j < K; j++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0; in_data_i = M'($urandom);
      end
      @(negedge clk);
      start_i = 1'b0; in_valid_i = 1'b1; in_data_i = pg[j];
    end
    for (int t = 0; t < RR + 4; t++) begin
      @(negedge clk);
      start_i = 1'b0; in_valid_i = noise; in_data_i = M'($urandom);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    cap_en = 0;

    exp_n = prefix + K + RR;
    chk(cap_n == exp_n, "R6/R8", "output byte count", cap_n, exp_n);
    if (cap_n != exp_n) return;
    for (int i = 0; i < prefix; i++)
      chk(cap_d[i] == pre[i], "R7", "aborted page byte", cap_d[i], pre[i]);
    dtag = (gap_pct > 0) ? "R9" : "R2";
    ok = 1;
    for (int j = 0; j < K; j++) if (cap_d[prefix+j] != pg[j]) ok = 0;
    chk(ok, dtag, "data bytes in order", ok, 1);
    chk(cap_d[prefix+K] == exp_col(), noise ? "R3/R4" : "R4", "column byte",
        cap_d[prefix+K], exp_col());
    for (int b = 0; b < RB; b++)
      chk(cap_d[prefix+K+1+b] == exp_row(b), noise ? "R3/R5" : "R5", "row byte",
          cap_d[prefix+K+1+b], exp_row(b));
    ok = 1;
    for (int i = 0; i < exp_n; i++) if (cap_l[i] != (i == exp_n - 1)) ok = 0;
    chk(ok, "R6", "last flag on final byte only", ok, 1);
    ok = 1;
    for (int i = prefix + K - 1; i < exp_n - 1; i++)
      if (cap_c[i+1] != cap_c[i] + 1) ok = 0;
    chk(ok, "R6", "check bytes consecutive", ok, 1);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; start_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid_o && !out_last_o, "R1", "outputs in reset", out_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !out_last_o, "R1", "outputs after reset", out_valid_o, 0);

    cap_n = 0; cap_en = 1;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_data_i = M'($urandom);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    @(negedge clk);
    cap_en = 0;
    chk(cap_n == 0, "R3", "bytes while idle", cap_n, 0);

    for (int j = 0; j < K; j++) pg[j] = '0;
    run_page(0, 1, 0, 0);
    pg[5] = 8'h01;
    run_page(0, 1, 0, 0);
    for (int j = 0; j < K; j++) pg[j] = '0;
    pg[10] = 8'h80;
    run_page(0, 0, 0, 0);
    for (int j = 0; j < K; j++) pg[j] = M'(j);
    run_page(0, 1, 0, 0);
    for (int r = 0; r < 12; r++) begin
      for (int j = 0; j < K; j++) pg[j] = M'($urandom);
      run_page((r % 4 == 3) ? 7 : 0, r[0], (r % 3 == 1) ? 40 : 0, r[1]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule